// File: doc/BRIEF.md
# Cache Line Burst Engine

This block sits between a writeback cache controller and a 32-bit Wishbone B3 master port. It moves a whole 128-bit cache line in one bus transaction. A line fill is a read and a writeback eviction is a write. Each transfer is a four-beat linear incrementing burst.

The cache asserts a request together with a direction flag, the line address and, for a write, the 128-bit line. The engine opens the bus cycle and steps through the beats, advancing one beat on every acknowledge. When the last beat has been acknowledged it closes the cycle and pulses its done strobe. A read line is then available on the 128-bit read port, and it stays there until the next read completes.

Top module: `wbl_line_engine`

## Requirements
- R1: While reset is high, and after it, with no request given, o_wb_cyc, o_wb_stb, o_wb_we and o_done are 0, o_wb_sel is 0000 and o_wb_cti is 000.
- R2: A request seen in a clock edge while the engine is idle raises o_wb_cyc and o_wb_stb in the next cycle. In that cycle o_wb_we equals the request's write flag (1 = write).
- R3: The first beat's address is the line base. Each beat acknowledged before the last raises o_wb_adr by 4 in the next cycle. Without an acknowledge the address holds.
- R4: o_wb_cti is 010 (incrementing burst) on beats 0, 1 and 2 and 111 (end of burst) on beat 3. o_wb_bte is always 00 (linear).
- R5: o_wb_cyc and o_wb_stb stay high together for the whole burst. The engine waits without limit for each acknowledge.
- R6: On a write, beat k drives line bits [32k+31:32k] on o_wb_dat with o_wb_sel = 1111.
- R7: On a read, the word on i_wb_dat acknowledged in beat k appears in o_rdata bits [32k+31:32k]. o_rdata is complete when o_done is high.
- R8: o_done is high for exactly one cycle, the cycle after the fourth acknowledge. In that same cycle o_wb_cyc and o_wb_stb are low.
- R9: A request raised while a burst is running is ignored. It changes no address, data or direction of the running burst, and no burst follows for it.
- R10: The low four address bits of a request are ignored. The burst starts at the request address with those bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous active-high reset |
| i_req | input | 1 | Line transfer request, taken only when idle |
| i_req_we | input | 1 | 1 = write line to bus, 0 = read line from bus |
| i_req_addr | input | 32 | Line address (low 4 bits ignored) |
| i_req_wdata | input | 128 | Line to write |
| o_rdata | output | 128 | Line read from the bus |
| o_done | output | 1 | One-cycle completion strobe |
| o_wb_cyc | output | 1 | Bus cycle active |
| o_wb_stb | output | 1 | Beat strobe |
| o_wb_adr | output | 32 | Beat byte address |
| o_wb_we | output | 1 | Bus write enable |
| o_wb_dat | output | 32 | Write data of the current beat |
| o_wb_sel | output | 4 | Byte selects |
| o_wb_cti | output | 3 | Cycle type indicator |
| o_wb_bte | output | 2 | Burst type indicator |
| i_wb_ack | input | 1 | Beat acknowledge |
| i_wb_dat | input | 32 | Read data of the current beat |

## Verification
A beat counter that has gone wrong shows at once on the bus. In the very beat where it diverges, the address, the cycle type or the write slice is wrong. A counter that skips or repeats also moves the done strobe one or more cycles away from the fourth acknowledge. A wrong read capture stays hidden until done, when o_rdata is compared with the words the slave returned. A state machine that accepts a request while busy shows as a changed address or direction in the next beat, or as a stray cycle after done.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
  typedef enum logic [2:0] {
    CTI_CLASSIC = 3'b000,
    CTI_INCR    = 3'b010,
    CTI_EOB     = 3'b111
  } cti_e;

  localparam logic [1:0] BTE_LINEAR = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BURST,
    ST_CLOSE
  } eng_state_e;
endpackage

// File: rtl/wbl_beat_ctrl.sv
module wbl_beat_ctrl #(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             i_clk,
  input  logic             i_rst,
  input  logic             i_req,
  input  logic             i_ack,
  output logic             o_launch,
  output logic             o_advance,
  output logic             o_finish,
  output logic             o_beat_ack,
  output logic [CNT_W-1:0] o_beat,
  output logic             o_cyc,
  output logic             o_done
);
  import wbl_pkg::*;

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             cyc_q, done_q;
  logic             last_beat;

  assign last_beat  = (cnt_q == CNT_W'(BEATS - 1));
  assign o_launch   = (state_q == ST_IDLE) && i_req;
  assign o_beat_ack = (state_q == ST_BURST) && i_ack;
  assign o_advance  = o_beat_ack && !last_beat;
  assign o_finish   = o_beat_ack && last_beat;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (i_req)    state_d = ST_BURST;
      ST_BURST: if (o_finish) state_d = ST_CLOSE;
      ST_CLOSE:               state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cyc_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= o_finish;
      if (o_launch) begin
        cnt_q <= '0;
        cyc_q <= 1'b1;
      end else if (o_advance) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (o_finish) begin
        cyc_q <= 1'b0;
      end
    end
  end

  assign o_beat = cnt_q;
  assign o_cyc  = cyc_q;
  assign o_done = done_q;

  // R8: completion strobe is a single cycle
  a_r8_done_single: assert property (@(posedge i_clk) disable iff (i_rst)
    done_q |=> !done_q);
  // R9: no new cycle is opened while one is running or closing
  a_r9_no_relaunch: assert property (@(posedge i_clk) disable iff (i_rst)
    (state_q != ST_IDLE) |=> !(cyc_q && $rose(cyc_q)));
endmodule

// File: rtl/wbl_addr_gen.sv
module wbl_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int BUS_W  = 32,
  localparam int LINE_BYTES = LINE_W / 8,
  localparam int STEP       = BUS_W / 8
) (
  input  logic              i_clk,
  input  logic              i_rst,
  input  logic              i_launch,
  input  logic              i_advance,
  input  logic [ADDR_W-1:0] i_addr,
  output logic [ADDR_W-1:0] o_adr
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0] adr_q;

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      adr_q <= '0;
    end else if (i_launch) begin
      adr_q <= i_addr & ~OFF_MASK;
    end else if (i_advance) begin
      adr_q <= adr_q + ADDR_W'(STEP);
    end
  end

  assign o_adr = adr_q;
endmodule

// File: rtl/wbl_line_buf.sv
module wbl_line_buf #(
  parameter int LINE_W = 128,
  parameter int BUS_W  = 32,
  localparam int BEATS = LINE_W / BUS_W,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             i_clk,
  input  logic             i_rst,
  input  logic             i_launch,
  input  logic             i_launch_we,
  input  logic             i_advance,
  input  logic             i_beat_ack,
  input  logic             i_we,
  input  logic [CNT_W-1:0] i_beat,
  input  logic [LINE_W-1:0] i_wline,
  input  logic [BUS_W-1:0] i_bus_rdat,
  output logic [BUS_W-1:0] o_bus_wdat,
  output logic [LINE_W-1:0] o_rline
);
  logic [LINE_W-1:0] wshift_q;
  logic              capture;

  // Outgoing line: a shift register whose low word is the current beat.
  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      wshift_q <= '0;
    end else if (i_launch) begin
      wshift_q <= i_launch_we ? i_wline : '0;
    end else if (i_advance) begin
      wshift_q <= wshift_q >> BUS_W;
    end
  end

  assign o_bus_wdat = wshift_q[BUS_W-1:0];
  assign capture    = i_beat_ack && !i_we;

  // Incoming line: one word register per beat slot.
  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge i_clk) begin
      if (i_rst) begin
        word_q <= '0;
      end else if (capture && (i_beat == CNT_W'(g))) begin
        word_q <= i_bus_rdat;
      end
    end
    assign o_rline[g*BUS_W +: BUS_W] = word_q;
  end
endmodule

// File: rtl/wbl_line_engine.sv
module wbl_line_engine #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int BUS_W  = 32,
  localparam int BEATS = LINE_W / BUS_W,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int SEL_W = BUS_W / 8
) (
  input  logic              i_clk,
  input  logic              i_rst,
  input  logic              i_req,
  input  logic              i_req_we,
  input  logic [ADDR_W-1:0] i_req_addr,
  input  logic [LINE_W-1:0] i_req_wdata,
  output logic [LINE_W-1:0] o_rdata,
  output logic              o_done,
  output logic              o_wb_cyc,
  output logic              o_wb_stb,
  output logic [ADDR_W-1:0] o_wb_adr,
  output logic              o_wb_we,
  output logic [BUS_W-1:0]  o_wb_dat,
  output logic [SEL_W-1:0]  o_wb_sel,
  output logic [2:0]        o_wb_cti,
  output logic [1:0]        o_wb_bte,
  input  logic              i_wb_ack,
  input  logic [BUS_W-1:0]  i_wb_dat
);
  import wbl_pkg::*;

  logic             launch, advance, finish, beat_ack, cyc;
  logic [CNT_W-1:0] beat;
  logic             we_q;
  logic [SEL_W-1:0] sel_q;
  cti_e             cti_q;

  wbl_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
    .i_clk(i_clk), .i_rst(i_rst), .i_req(i_req), .i_ack(i_wb_ack),
    .o_launch(launch), .o_advance(advance), .o_finish(finish),
    .o_beat_ack(beat_ack), .o_beat(beat), .o_cyc(cyc), .o_done(o_done)
  );

  wbl_addr_gen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .BUS_W(BUS_W)) u_addr (
    .i_clk(i_clk), .i_rst(i_rst), .i_launch(launch), .i_advance(advance),
    .i_addr(i_req_addr), .o_adr(o_wb_adr)
  );

  wbl_line_buf #(.LINE_W(LINE_W), .BUS_W(BUS_W)) u_buf (
    .i_clk(i_clk), .i_rst(i_rst), .i_launch(launch), .i_launch_we(i_req_we),
    .i_advance(advance), .i_beat_ack(beat_ack), .i_we(we_q), .i_beat(beat),
    .i_wline(i_req_wdata), .i_bus_rdat(i_wb_dat),
    .o_bus_wdat(o_wb_dat), .o_rline(o_rdata)
  );

  always_ff @(posedge i_clk) begin
    if (i_rst) begin
      we_q  <= 1'b0;
      sel_q <= '0;
      cti_q <= CTI_CLASSIC;
    end else if (launch) begin
      we_q  <= i_req_we;
      sel_q <= '1;
      cti_q <= (BEATS == 1) ? CTI_EOB : CTI_INCR;
    end else if (advance) begin
      cti_q <= (beat == CNT_W'(BEATS - 2)) ? CTI_EOB : CTI_INCR;
    end else if (finish) begin
      we_q  <= 1'b0;
      sel_q <= '0;
      cti_q <= CTI_CLASSIC;
    end
  end

  assign o_wb_cyc = cyc;
  assign o_wb_stb = cyc;
  assign o_wb_we  = we_q;
  assign o_wb_sel = sel_q;
  assign o_wb_cti = cti_q;
  assign o_wb_bte = BTE_LINEAR;

  // R3: address holds while a beat is stalled
  a_r3_adr_hold: assert property (@(posedge i_clk) disable iff (i_rst)
    (o_wb_cyc && !i_wb_ack) |=> $stable(o_wb_adr));
  // R3: address steps by one bus word after each non-final beat
  a_r3_adr_step: assert property (@(posedge i_clk) disable iff (i_rst)
    (o_wb_cyc && i_wb_ack && o_wb_cti == CTI_INCR) |=>
      (o_wb_adr == $past(o_wb_adr) + ADDR_W'(SEL_W)));
  // R8: acknowledged final beat closes the cycle and raises done
  a_r8_close: assert property (@(posedge i_clk) disable iff (i_rst)
    (o_wb_cyc && i_wb_ack && o_wb_cti == CTI_EOB) |=> (o_done && !o_wb_cyc));
  // R8: the cycle only ends through completion
  a_r8_fall_done: assert property (@(posedge i_clk) disable iff (i_rst)
    $fell(o_wb_cyc) |-> o_done);
  // R4: an open cycle never shows the classic code
  a_r4_cti_burst: assert property (@(posedge i_clk) disable iff (i_rst)
    o_wb_cyc |-> (o_wb_cti == CTI_INCR || o_wb_cti == CTI_EOB));
  // R6: full byte lanes on every write beat
  a_r6_sel_full: assert property (@(posedge i_clk) disable iff (i_rst)
    (o_wb_cyc && o_wb_we) |-> (o_wb_sel == '1));
endmodule

// File: tb/wbl_line_engine_test.sv
module wbl_line_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, req, req_we, done, cyc, stb, we, ack;
  logic [31:0]  req_addr, adr, dat, idat;
  logic [127:0] req_wdata, rdata;
  logic [3:0]   sel;
  logic [2:0]   cti;
  logic [1:0]   bte;
  int checks = 0, fails = 0, cycles = 0;

  wbl_line_engine uut (
    .i_clk(clk), .i_rst(rst), .i_req(req), .i_req_we(req_we),
    .i_req_addr(req_addr), .i_req_wdata(req_wdata), .o_rdata(rdata),
    .o_done(done), .o_wb_cyc(cyc), .o_wb_stb(stb), .o_wb_adr(adr),
    .o_wb_we(we), .o_wb_dat(dat), .o_wb_sel(sel), .o_wb_cti(cti),
    .o_wb_bte(bte), .i_wb_ack(ack), .i_wb_dat(idat)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] line_base(input logic [31:0] a);
    return a & ~32'hF;
  endfunction

  function automatic logic [2:0] exp_cti(input int k);
    return (k == 3) ? 3'b111 : 3'b010;
  endfunction

  task automatic run_burst(input bit w, input logic [31:0] a, input logic [127:0] wd,
                           input int ackpct, input bit poke);
    logic [127:0] rexp = '0;
    logic [31:0]  base = line_base(a);
    int beat = 0, guard = 0;
    bit poked = 0;
    @(negedge clk);
    req = 1; req_we = w; req_addr = a; req_wdata = wd; ack = 0;
    @(negedge clk);
    req = 0;
    chk(cyc === 1'b1 && we === w, "R2", {cyc, we}, {1'b1, w});
    while (beat < 4 && guard < 5000) begin
      guard++;
      chk(cyc === 1'b1 && stb === 1'b1, "R5", {cyc, stb}, 2'b11);
      chk(adr === base + 32'(4 * beat), "R3/R10", adr, base + 32'(4 * beat));
      chk(cti === exp_cti(beat), "R4", cti, exp_cti(beat));
      chk(bte === 2'b00, "R4", bte, 2'b00);
      chk(we === w, "R9", we, w);
      if (w) begin
        chk(dat === wd[32*beat +: 32], "R6", dat, wd[32*beat +: 32]);
        chk(sel === 4'hF, "R6", sel, 4'hF);
      end
      if (poke && beat == 1 && !poked) begin
        req = 1; req_we = ~w; req_addr = a + 32'h100; req_wdata = ~wd;
        poked = 1; ack = 0;
      end else begin
        req = 0;
        ack = (($urandom % 100) < ackpct);
      end
      idat = $urandom;
      if (ack) begin
        rexp[32*beat +: 32] = idat;
        beat++;
      end
      @(negedge clk);
    end
    ack = 0; req = 0;
    chk(done === 1'b1 && cyc === 1'b0 && stb === 1'b0, "R8", {done, cyc, stb}, 3'b100);
    if (!w) chk(rdata === rexp, "R7", rdata, rexp);
    @(negedge clk);
    chk(done === 1'b0, "R8", done, 1'b0);
    chk(cyc === 1'b0, "R9", cyc, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; req = 0; req_we = 0; req_addr = '0; req_wdata = '0; ack = 0; idat = '0;
    repeat (3) @(negedge clk);
    chk(cyc === 0 && stb === 0 && done === 0 && we === 0, "R1", {cyc, stb, done, we}, 4'b0);
    chk(cti === 3'b000 && sel === 4'h0, "R1", {cti, sel}, 7'b0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk(cyc === 0 && done === 0, "R1", {cyc, done}, 2'b0);
    // directed: back-to-back ack write, stalled read, misaligned address, busy request
    run_burst(1, 32'h0000_1000, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 100, 0);
    run_burst(0, 32'h0000_2000, '0, 100, 0);
    run_burst(0, 32'h8000_0040, '0, 4, 0);
    run_burst(1, 32'h1234_567B, 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678, 50, 0);
    run_burst(0, 32'hFFFF_FFFF, '0, 60, 1);
    run_burst(1, 32'h0000_3008, 128'hA5A5_0001_5A5A_0002_F0F0_0003_0F0F_0004, 70, 1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      run_burst($urandom % 2, $urandom, {$urandom, $urandom, $urandom, $urandom},
                20 + ($urandom % 81), ($urandom % 4) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule